// File: doc/BRIEF.md
# Interrupt-Capable Microprogram Sequencer

This block steps through the control store of a microprogrammed CPU and adds one level of interrupt service. A 5-bit address counter selects a word from a 32-entry control store. The word goes to the datapath as the current control word. In the absence of events the address advances by one every clock.

An interrupt request taken while the foreground program runs saves the address that follows the current one in a dedicated return register. The counter then jumps to a fixed handler vector. The handler ends when either an external release line or the least significant bit of the word being fetched is seen high. One clock later the counter reloads the saved address and the foreground program resumes.

A small three-state machine tracks the foreground, the save cycle and the handler. It blocks nested requests and ignores releases outside a handler. The control store contents come from a parameter, so any microprogram can be built in without external files.

Top module: `useq_irq_top`

## Requirements
- R1: Outside reset and without a taken request or due return, the address advances by one per clock and wraps from 31 to 0. The control word always equals the store entry at the current address. The default store holds the address in bits [7:1], and bit 0 is set only at address 20.
- R2: A request taken at address A writes (A+1) mod 32 into the return register; 31 therefore saves 0.
- R3: A request taken in the foreground loads the vector address 16 at the next edge, and counting continues upward from there.
- R4: A handler is released either by the external release input or by bit 0 (least significant bit) of the current control word.
- R5: A release seen at clock edge k still lets edge k increment the address. Edge k+1 loads the saved return address and resumes the foreground.
- R6: A release is accepted in the vector cycle itself, the first cycle after the request is taken, as well as later in the handler.
- R7: Synchronous active-high reset sets the address to 0 with the control word for address 0 and abandons any handler. The return register is cleared.
- R8: A request that arrives while a handler is in progress has no effect, including in the cycle where a pending return fires.
- R9: A release in the foreground has no effect, whether it comes from the external line or from bit 0 of the control word.
- R10: When a request and an external release arrive together in the foreground, the request is taken and the release is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request |
| rel | input | 1 | External handler release |
| addr | output | ADDR_W (5) | Current control-store address |
| cw | output | CW_W (8) | Current control word to the datapath |

## Verification
The bench uses the default parameters: 5-bit addresses, an 8-bit control word, vector 16 and the release word at address 20. With 32 addresses, the wrap from 31 to 0 and the save of return address 0 are reached within a few dozen cycles. The default store makes every word predictable from its address, and the foreground run crosses the release word at address 20 while no handler is active. Directed tasks place requests and releases in the vector cycle, in the firing cycle and together in one cycle, so each ordering rule is checked by an exact address sequence.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int IMG_W = 1024;

  typedef enum logic [1:0] {
    SEQ_FG   = 2'd0,
    SEQ_SAVE = 2'd1,
    SEQ_ISR  = 2'd2
  } seq_state_t;

  function automatic logic [IMG_W-1:0] rom_image(input int aw, input int cww, input int rel_at);
    logic [IMG_W-1:0] img;
    logic [63:0]      word;
    img = '0;
    for (int i = 0; i < (1 << aw); i++) begin
      word = (64'(i) << 1) | 64'(i == rel_at);
      for (int b = 0; b < cww; b++) begin
        if (i * cww + b < IMG_W) img[i*cww+b] = word[b];
      end
    end
    return img;
  endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom #(
  parameter int ADDR_W = 5,
  parameter int CW_W   = 8,
  parameter logic [useq_pkg::IMG_W-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CW_W-1:0]   cw_q
);
  localparam int DEPTH = 1 << ADDR_W;

  initial begin
    assert (DEPTH * CW_W <= useq_pkg::IMG_W)
      else $error("control store image too small");
  end

  logic [CW_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign mem[g] = INIT[g*CW_W +: CW_W];
  end

  always_ff @(posedge clk) begin
    cw_q <= mem[rd_addr];
  end

endmodule

// File: rtl/useq_addr.sv
module useq_addr #(
  parameter int ADDR_W   = 5,
  parameter int VEC_ADDR = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_vec,
  input  logic              load_ret,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] addr_nxt
);
  localparam logic [ADDR_W-1:0] VEC = ADDR_W'(VEC_ADDR);

  logic [ADDR_W-1:0] ret_q;
  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] mux_out;

  assign inc     = addr_q + 1'b1;
  assign mux_out = load_vec ? VEC : ret_q;

  always_comb begin
    if (rst)                      addr_nxt = '0;
    else if (load_vec | load_ret) addr_nxt = mux_out;
    else                          addr_nxt = inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      ret_q  <= '0;
    end else begin
      addr_q <= addr_nxt;
      if (load_vec) ret_q <= inc;
    end
  end

  p_inc_r1: assert property (@(posedge clk) disable iff (rst)
    (!load_vec && !load_ret) |=> addr_q == $past(addr_q) + 1'b1);
  p_ret_save_r2: assert property (@(posedge clk) disable iff (rst)
    load_vec |=> ret_q == $past(addr_q) + 1'b1);
  p_vec_load_r3: assert property (@(posedge clk) disable iff (rst)
    load_vec |=> addr_q == VEC);
  p_ret_load_r5: assert property (@(posedge clk) disable iff (rst)
    load_ret |=> addr_q == $past(ret_q));

endmodule

// File: rtl/useq_fsm.sv
module useq_fsm
  import useq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic irq,
  input  logic rel_ext,
  input  logic cw_rel,
  output logic load_vec,
  output logic load_ret
);
  seq_state_t state_q, state_d;
  logic       rel_arm_q, rel_arm_d;
  logic       in_handler;
  logic       rel_req;

  assign in_handler = (state_q != SEQ_FG);
  assign rel_req    = rel_ext | cw_rel;
  assign load_vec   = (state_q == SEQ_FG) && irq;
  assign load_ret   = rel_arm_q;

  always_comb begin
    state_d   = state_q;
    rel_arm_d = 1'b0;
    case (state_q)
      SEQ_FG:   if (irq) state_d = SEQ_SAVE;
      SEQ_SAVE: begin
        state_d   = SEQ_ISR;
        rel_arm_d = rel_req;
      end
      SEQ_ISR: begin
        if (rel_arm_q) state_d = SEQ_FG;
        else           rel_arm_d = rel_req;
      end
      default:  state_d = SEQ_FG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEQ_FG;
      rel_arm_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      rel_arm_q <= rel_arm_d;
    end
  end

  p_release_src_r4: assert property (@(posedge clk) disable iff (rst)
    (in_handler && !rel_arm_q && (rel_ext || cw_rel)) |=> load_ret);
  p_save_then_isr_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_SAVE) |=> (state_q == SEQ_ISR));
  p_no_nest_r8: assert property (@(posedge clk) disable iff (rst)
    (in_handler && irq) |-> !load_vec);
  p_fg_rel_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (!in_handler) |=> !load_ret);
  p_irq_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (!in_handler && irq && rel_ext) |=> (state_q == SEQ_SAVE && !load_ret));

endmodule

// File: rtl/useq_irq_top.sv
module useq_irq_top #(
  parameter int ADDR_W   = 5,
  parameter int CW_W     = 8,
  parameter int VEC_ADDR = 16,
  parameter int REL_ADDR = 20,
  parameter logic [useq_pkg::IMG_W-1:0] ROM_INIT =
    useq_pkg::rom_image(ADDR_W, CW_W, REL_ADDR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq,
  input  logic              rel,
  output logic [ADDR_W-1:0] addr,
  output logic [CW_W-1:0]   cw
);
  logic              load_vec;
  logic              load_ret;
  logic [ADDR_W-1:0] addr_nxt;

  useq_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .rel_ext  (rel),
    .cw_rel   (cw[0]),
    .load_vec (load_vec),
    .load_ret (load_ret)
  );

  useq_addr #(
    .ADDR_W   (ADDR_W),
    .VEC_ADDR (VEC_ADDR)
  ) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load_vec (load_vec),
    .load_ret (load_ret),
    .addr_q   (addr),
    .addr_nxt (addr_nxt)
  );

  useq_rom #(
    .ADDR_W (ADDR_W),
    .CW_W   (CW_W),
    .INIT   (ROM_INIT)
  ) u_rom (
    .clk     (clk),
    .rd_addr (addr_nxt),
    .cw_q    (cw)
  );

  p_reset_r7: assert property (@(posedge clk)
    rst |=> (addr == '0 && !load_ret));
  p_cw_tracks_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cw == ROM_INIT[addr*CW_W +: CW_W]);

endmodule

// File: tb/useq_irq_top_tb.sv
module useq_irq_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       irq = 1'b0;
  logic       rel = 1'b0;
  logic [4:0] addr;
  logic [7:0] cw;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_irq_top u_dut (
    .clk  (clk),
    .rst  (rst),
    .irq  (irq),
    .rel  (rel),
    .addr (addr),
    .cw   (cw)
  );

  function automatic logic [7:0] exp_cw(input int a);
    return 8'((a << 1) | ((a == 20) ? 1 : 0));
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_addr(input string tag, input int exp);
    check(tag, int'(addr), exp);
    check({tag, " cw"}, int'(cw), int'(exp_cw(exp)));
  endtask

  task automatic goto_addr(input int a);
    for (int i = 0; i < 64; i++) begin
      if (int'(addr) == a) break;
      tick();
    end
    check("goto", int'(addr), a);
  endtask

  task automatic take_irq();
    irq = 1'b1;
    tick();
    irq = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    check_addr("R7 reset address", 0);
    rst = 1'b0;
  endtask

  task automatic t_count();
    for (int i = 1; i <= 5; i++) begin
      tick();
      check_addr("R1 increment", i);
    end
    goto_addr(20);
    check("R9 rel bit present in fg", int'(cw[0]), 1);
    tick();
    check_addr("R9 cw release ignored in fg", 21);
    tick();
    check_addr("R9 no delayed load in fg", 22);
    goto_addr(31);
    tick();
    check_addr("R1 wrap to zero", 0);
  endtask

  task automatic t_irq_cwrel();
    goto_addr(5);
    take_irq();
    check_addr("R3 vector load", 16);
    for (int a = 17; a <= 21; a++) begin
      tick();
      check_addr("R3 handler counting", a);
    end
    tick();
    check_addr("R5 return after cw bit0 R4 R2", 6);
  endtask

  task automatic t_ext_rel();
    goto_addr(9);
    take_irq();
    tick();
    check_addr("R4 handler before release", 17);
    rel = 1'b1;
    tick();
    rel = 1'b0;
    check_addr("R5 release edge still increments", 18);
    tick();
    check_addr("R5 external release return", 10);
  endtask

  task automatic t_rel_vec_cycle();
    goto_addr(2);
    take_irq();
    rel = 1'b1;
    tick();
    rel = 1'b0;
    check_addr("R6 release in vector cycle", 17);
    tick();
    check_addr("R6 return from vector-cycle release", 3);
  endtask

  task automatic t_nest();
    goto_addr(12);
    take_irq();
    tick();
    irq = 1'b1;
    tick();
    irq = 1'b0;
    check_addr("R8 nested request ignored", 18);
    goto_addr(21);
    irq = 1'b1;
    tick();
    irq = 1'b0;
    check_addr("R8 request in firing cycle ignored", 13);
    tick();
    check_addr("R8 foreground continues", 14);
  endtask

  task automatic t_fg_rel();
    goto_addr(3);
    rel = 1'b1;
    tick();
    rel = 1'b0;
    check_addr("R9 external release in fg", 4);
    tick();
    check_addr("R9 no later load", 5);
  endtask

  task automatic t_both();
    goto_addr(7);
    irq = 1'b1;
    rel = 1'b1;
    tick();
    irq = 1'b0;
    rel = 1'b0;
    check_addr("R10 request wins", 16);
    tick();
    check_addr("R10 release discarded", 17);
    tick();
    check_addr("R10 still in handler", 18);
    goto_addr(21);
    tick();
    check_addr("R10 return via cw bit0", 8);
  endtask

  task automatic t_wrap_ret();
    goto_addr(31);
    take_irq();
    check_addr("R2 vector from 31", 16);
    goto_addr(21);
    tick();
    check_addr("R2 saved address wraps to 0", 0);
  endtask

  task automatic t_reset_mid();
    goto_addr(4);
    take_irq();
    tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check_addr("R7 reset abandons handler", 0);
    goto_addr(21);
    tick();
    check_addr("R7 no return after reset", 22);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick();
    t_reset();
    t_count();
    t_irq_cwrel();
    t_ext_rel();
    t_rel_vec_cycle();
    t_nest();
    t_fg_rel();
    t_both();
    t_wrap_ret();
    t_reset_mid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule